// File: doc/BRIEF.md
# PWM Prescaler Tick Generator

This block supplies the time base for a multi-channel PWM controller. It does not produce gated clocks. Every output is a clock-enable tick, one master-clock cycle wide, so all downstream channel logic runs on the single master clock. A free-running prescale counter produces eleven ticks. Tick k fires once every 2^k master cycles, for k from 0 to 10, which covers divide-by-1 up to divide-by-1024.

Two linear dividers, A and B, sit behind the prescaler and are fully independent. Each has a source-select field that picks one of the eleven prescaler ticks. Each also has an 8-bit divide field, and the divider emits one tick for every that-many source ticks. A divide value of zero turns the divider off. A select value beyond the last tap also turns it off. Loading a new divide value restarts the divider's count.

The global enable input gates the prescaler. While the enable is low, only the undivided tick (tap 0) stays active. The prescale count also returns to zero, so every power-of-two tick starts in phase when the enable rises again.

Top module: `pwm_tick_gen`

## Requirements
- R1: `taps[0]` is high in every cycle after reset, whatever the level of `en`.
- R2: While `en` is high, tap k (k = 1..10) is high exactly in the cycles where c+1 is a multiple of 2^k. Here c counts the cycles since `en` was last low, starting at 0 in the first enabled cycle and wrapping at 1024.
- R3: While `en` is low, `taps[10:1]` are all zero and the prescale count returns to zero.
- R4: Divider A's source tick is `taps[sel_a]`. `tick_a` is high on the `div_a`-th source tick after the divide value was loaded, and then on every `div_a`-th source tick after that.
- R5: Divider B behaves as R4 with `sel_b`, `div_b` and `tick_b`, independently of divider A.
- R6: A divide value of 0 keeps that divider's tick low.
- R7: A select value of 11 to 15 keeps that divider's tick low.
- R8: In a cycle where a divider's divide value differs from the value it held in the previous cycle, that divider's tick is low. Its count then restarts, so the first tick comes on the new divide value's source tick after the change. The value held during reset counts as 0.
- R9: During reset, `taps` reads 1 (only tap 0 high) and both divider ticks are low.
- R10: With a select value of 1 to 10, a divider tick never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Global prescaler enable |
| sel_a | input | 4 | Source tap select for divider A |
| div_a | input | 8 | Divide value for divider A, 0 = off |
| sel_b | input | 4 | Source tap select for divider B |
| div_b | input | 8 | Divide value for divider B, 0 = off |
| taps | output | 11 | Power-of-two ticks; bit k fires every 2^k cycles |
| tick_a | output | 1 | Divider A tick |
| tick_b | output | 1 | Divider B tick |

## Verification
All outputs are combinational decodes of registered counts and the present inputs. A change to `en`, a select field or a divide field therefore shows on the outputs in the same cycle. The counts it causes take effect from the next cycle onward. The bench drives inputs just after the falling edge and compares the outputs 4 ns later, before the rising edge. It advances its own arithmetic model (enabled-cycle count and per-divider source-tick count) at the rising edge, so each expected value is due in exactly the cycle the outputs are read. The sweep covers every select value from 0 to 12 against a set of divide values. A long enabled run reaches the divide-by-1024 tap.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;

  // True when the low k bits of v are all ones: the power-of-two tap k is due.
  function automatic logic low_ones(input logic [31:0] v, input int unsigned k);
    logic [31:0] mask;
    mask = (32'd1 << k) - 32'd1;
    return (v & mask) == mask;
  endfunction

  // True when a divider count has reached its terminal value for divide d.
  function automatic logic at_terminal(input logic [31:0] cnt, input logic [31:0] d);
    return (d != 32'd0) && (cnt + 32'd1 == d);
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned N_TAPS = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  output logic [N_TAPS-1:0] taps,
  output logic [N_TAPS-2:0] cnt_o
);
  import pwm_tick_pkg::*;
  localparam int unsigned CW = N_TAPS - 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (en)  cnt_q <= cnt_q + 1'b1;
    else          cnt_q <= '0;
  end

  assign taps[0] = 1'b1;

  for (genvar k = 1; k < N_TAPS; k++) begin : g_tap
    assign taps[k] = en && low_ones(32'(cnt_q), k);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_lin_div.sv
module pwm_lin_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tick,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick,
  output logic [DIV_W-1:0] cnt_o,
  output logic             chg_o
);
  import pwm_tick_pkg::*;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  logic             chg;
  logic             live;
  logic             last;

  assign chg  = (div_val != div_q);
  assign live = (div_val != '0);
  assign last = at_terminal(32'(cnt_q), 32'(div_val));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= '0;
    end else begin
      div_q <= div_val;
      if (chg)                   cnt_q <= '0;
      else if (src_tick && live) cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick  = src_tick && live && !chg && last;
  assign cnt_o = cnt_q;
  assign chg_o = chg;
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int unsigned N_TAPS = 11,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [SEL_W-1:0]  sel_a,
  input  logic [DIV_W-1:0]  div_a,
  input  logic [SEL_W-1:0]  sel_b,
  input  logic [DIV_W-1:0]  div_b,
  output logic [N_TAPS-1:0] taps,
  output logic              tick_a,
  output logic              tick_b
);
  localparam int unsigned N_DIV = 2;

  logic [N_TAPS-2:0] pre_cnt;
  logic [SEL_W-1:0]  sel_v [N_DIV];
  logic [DIV_W-1:0]  div_v [N_DIV];
  logic [DIV_W-1:0]  dcnt  [N_DIV];
  logic [N_DIV-1:0]  sel_tick;
  logic [N_DIV-1:0]  chg;
  logic [N_DIV-1:0]  tick_v;
  logic [DIV_W-1:0]  dcnt_a;
  logic [DIV_W-1:0]  dcnt_b;

  pwm_prescaler #(.N_TAPS(N_TAPS)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .taps  (taps),
    .cnt_o (pre_cnt)
  );

  assign sel_v[0] = sel_a;
  assign sel_v[1] = sel_b;
  assign div_v[0] = div_a;
  assign div_v[1] = div_b;

  for (genvar d = 0; d < N_DIV; d++) begin : g_div
    assign sel_tick[d] = (int'(sel_v[d]) < N_TAPS) ? taps[sel_v[d]] : 1'b0;

    pwm_lin_div #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_tick (sel_tick[d]),
      .div_val  (div_v[d]),
      .tick     (tick_v[d]),
      .cnt_o    (dcnt[d]),
      .chg_o    (chg[d])
    );
  end

  assign tick_a = tick_v[0];
  assign tick_b = tick_v[1];
  assign dcnt_a = dcnt[0];
  assign dcnt_b = dcnt[1];
endmodule

// File: rtl/pwm_tick_chk.sv
module pwm_tick_chk #(
  parameter int unsigned N_TAPS = 11,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned DIV_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [SEL_W-1:0]  sel_a,
  input logic [DIV_W-1:0]  div_a,
  input logic [SEL_W-1:0]  sel_b,
  input logic [DIV_W-1:0]  div_b,
  input logic [N_TAPS-1:0] taps,
  input logic              tick_a,
  input logic              tick_b,
  input logic [N_TAPS-2:0] pre_cnt,
  input logic [1:0]        sel_tick,
  input logic [1:0]        chg,
  input logic [DIV_W-1:0]  dcnt_a,
  input logic [DIV_W-1:0]  dcnt_b
);
  AST_IDLE_TAPS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> taps[N_TAPS-1:1] == '0); // R3
  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> pre_cnt == '0); // R3
  AST_SRC_A: assert property (@(posedge clk) disable iff (!rst_n)
    tick_a |-> sel_tick[0]); // R4
  AST_BOUND_A: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg[0] && div_a != '0) |-> dcnt_a < div_a); // R4
  AST_SRC_B: assert property (@(posedge clk) disable iff (!rst_n)
    tick_b |-> sel_tick[1]); // R5
  AST_OFF_A: assert property (@(posedge clk) disable iff (!rst_n)
    div_a == '0 |-> !tick_a); // R6
  AST_OFF_B: assert property (@(posedge clk) disable iff (!rst_n)
    div_b == '0 |-> !tick_b); // R6
  AST_SEL_RANGE_A: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel_a) >= N_TAPS |-> !tick_a); // R7
  AST_SEL_RANGE_B: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel_b) >= N_TAPS |-> !tick_b); // R7
  AST_RESTART_A: assert property (@(posedge clk) disable iff (!rst_n)
    chg[0] |=> dcnt_a == '0); // R8
  AST_RESTART_B: assert property (@(posedge clk) disable iff (!rst_n)
    chg[1] |=> dcnt_b == '0); // R8
  AST_WIDTH_A: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_a && sel_a != '0 && int'(sel_a) < N_TAPS) |=> (sel_a != $past(sel_a) || !tick_a)); // R10
endmodule

bind pwm_tick_gen pwm_tick_chk #(.N_TAPS(N_TAPS), .SEL_W(SEL_W), .DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .sel_a    (sel_a),
  .div_a    (div_a),
  .sel_b    (sel_b),
  .div_b    (div_b),
  .taps     (taps),
  .tick_a   (tick_a),
  .tick_b   (tick_b),
  .pre_cnt  (pre_cnt),
  .sel_tick (sel_tick),
  .chg      (chg),
  .dcnt_a   (dcnt_a),
  .dcnt_b   (dcnt_b)
);

// File: tb/sim_pwm_tick_gen.sv
module sim_pwm_tick_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [3:0]  sel_a = '0, sel_b = '0;
  logic [7:0]  div_a = '0, div_b = '0;
  logic [10:0] taps;
  logic        tick_a, tick_b;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // Bench model state
  int pc = 0;                 // enabled cycles since en was last low
  int ksrc [2] = '{0, 0};     // source ticks counted since last divide change
  int prev_div [2] = '{0, 0};

  always #5 clk = ~clk;

  pwm_tick_gen u0 (
    .clk(clk), .rst_n(rst_n), .en(en),
    .sel_a(sel_a), .div_a(div_a), .sel_b(sel_b), .div_b(div_b),
    .taps(taps), .tick_a(tick_a), .tick_b(tick_b)
  );

  function automatic logic [10:0] exp_taps(input bit e, input int c);
    logic [10:0] t;
    t = 11'd1;
    for (int k = 1; k < 11; k++)
      t[k] = e && (((c + 1) % (1 << k)) == 0);
    return t;
  endfunction

  task automatic check_div(input int d, input int s, input int dv, input logic got,
                           input logic [10:0] et);
    bit src, chgd, expv;
    string tag;
    src  = (s <= 10) ? et[s] : 1'b0;
    chgd = (dv != prev_div[d]);
    expv = src && !chgd && dv != 0 && (((ksrc[d] + 1) % ((dv == 0) ? 1 : dv)) == 0);
    if (dv == 0)      tag = "R6";
    else if (s > 10)  tag = "R7";
    else if (chgd)    tag = "R8";
    else if (d == 0)  tag = "R4";
    else              tag = "R5";
    n_run++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s tick_%s sel=%0d div=%0d got=%0b exp=%0b", tag, (d == 0) ? "a" : "b",
               s, dv, got, expv);
    end
  endtask

  // One cycle: inputs already set after negedge; check before posedge, advance at posedge.
  task automatic step();
    logic [10:0] et;
    int sv [2];
    int dvv [2];
    #4;
    et = exp_taps(en, pc);
    n_run++;
    if (taps !== et) begin
      n_fail++;
      $display("FAIL %s taps got=%b exp=%b", (taps[0] !== 1'b1) ? "R1" : (!en ? "R3" : "R2"),
               taps, et);
    end
    sv[0] = int'(sel_a); sv[1] = int'(sel_b);
    dvv[0] = int'(div_a); dvv[1] = int'(div_b);
    check_div(0, sv[0], dvv[0], tick_a, et);   // also covers R10 through the tick pattern
    check_div(1, sv[1], dvv[1], tick_b, et);
    @(posedge clk);
    pc = en ? (pc + 1) % 1024 : 0;
    for (int d = 0; d < 2; d++) begin
      if (dvv[d] != prev_div[d]) ksrc[d] = 0;
      else if (sv[d] <= 10 && dvv[d] != 0 && et[sv[d]]) ksrc[d]++;
      prev_div[d] = dvv[d];
    end
    @(negedge clk);
  endtask

  task automatic run_cfg(input int sa, input int da, input int sb, input int db,
                         input int n, input int idle);
    sel_a = 4'(sa); div_a = 8'(da); sel_b = 4'(sb); div_b = 8'(db);
    for (int i = 0; i < n; i++) begin
      en = (i >= idle);
      step();
    end
  endtask

  initial begin
    int dl [5] = '{0, 1, 2, 3, 7};
    repeat (2) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      #4;
      n_run++;
      if (taps !== 11'd1 || tick_a !== 1'b0 || tick_b !== 1'b0) begin
        n_fail++;
        $display("FAIL R9 reset taps=%b a=%0b b=%0b exp taps=00000000001 a=0 b=0",
                 taps, tick_a, tick_b);
      end
      @(negedge clk);
    end
    rst_n = 1'b1;
    // Sweep every select value against a set of divide values (R4..R8, R10).
    for (int sa = 0; sa < 13; sa++)
      for (int di = 0; di < 5; di++)
        run_cfg(sa, dl[di], 12 - sa, dl[4 - di], 250, ((sa + di) % 3 == 0) ? 3 : 0);
    // Long enabled run reaching the slowest tap (R2) with divided top taps.
    run_cfg(10, 2, 9, 3, 3000, 2);
    // Idle then restart of the prescaler (R3, R1).
    run_cfg(3, 4, 0, 5, 40, 10);
    // Divide change mid-stream (R8).
    run_cfg(1, 3, 2, 2, 30, 0);
    run_cfg(1, 4, 2, 5, 60, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule